// File: doc/BRIEF.md
# Time-Synchronisation Counter with Coherent Snapshot Reader

The block keeps a free-running 64-bit microsecond time base for a wireless MAC. It advances once for every microsecond tick it is given and wraps to zero after all ones. A host register port sees the counter as two 32-bit halves plus a control word. Software sets a new time by writing the low half, which waits in a shadow register, and then the high half, which commits both halves in one cycle. A toggle bit in the control word clears the counter. The bit acts on each write, so software writes it twice to leave no request pending.

The counter can also jump at any cycle. This happens when a received frame from the same network carries a new time, and it is modelled as a load strobe with a 64-bit value. Because of these jumps, and because of carries from the low half into the high half, two plain reads of the halves can tear. A built-in snapshot reader avoids this. It reads the upper half, then the lower half and the upper half again. If the two upper values differ it keeps the newer one and retries. It stops after a bounded number of comparisons, and if every one mismatched it returns the last composed value with a warning flag set.

Top module: `tsf_timer_top`

## Requirements
- R1: After synchronous reset the counter, the shadow register and the toggle flag are zero, and `snap_busy`, `snap_valid`, `snap_warn` and `snap_value` are zero.
- R2: On a cycle with `tick_us` high and no load, high-half write or counter clear, the counter grows by one. The carry passes from bit 31 into bit 32, and all ones wraps to zero.
- R3: A write to address 0 only stores the data in the shadow register. The visible counter keeps its value, or keeps ticking.
- R4: A write to address 1 loads the counter with {write data, shadow} at that clock edge. This wins over a beacon load and a tick in the same cycle.
- R5: A write to address 2 with data bit 0 set toggles the reset flag. A 0-to-1 toggle clears the counter at that edge, winning over a load and a tick. A 1-to-0 toggle leaves the counter alone. Bit 0 clear has no effect.
- R6: With `bcn_load` high and no high-half write or clear, the counter takes `bcn_time`, winning over a tick.
- R7: `bus_rdata` shows the current state without delay: address 0 the counter's low half, 1 its high half, 2 the toggle flag in bit 0 with zeros above, 3 zero. Writes to address 3 have no effect.
- R8: A `snap_req` seen while idle starts a read and raises `snap_busy` on the next cycle. The reader samples the upper half at the first edge after acceptance, the lower half at the next edge and the upper half again at the edge after that. If both upper samples match, `snap_valid` rises at that edge with `snap_warn` low.
- R9: On a mismatch the newer upper sample replaces the old one, and the lower and upper samples are taken again. After 10 mismatching comparisons the reader completes with `snap_warn` high. In every case `snap_value` is {last upper sample, last lower sample}.
- R10: `snap_valid` lasts one cycle. `snap_value` and `snap_warn` hold until the next completion. `snap_req` while busy is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle microsecond tick |
| bcn_load | input | 1 | Load strobe from beacon reception |
| bcn_time | input | 64 | Time carried by the received beacon |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 32 | Read data, combinational |
| snap_req | input | 1 | Start a coherent snapshot |
| snap_busy | output | 1 | Snapshot in progress |
| snap_valid | output | 1 | One-cycle completion strobe |
| snap_value | output | 64 | Composed 64-bit snapshot |
| snap_warn | output | 1 | Completed without two matching upper samples |

## Verification
The collisions of interest are a beacon load, or a carry from a tick, arriving between the reader's upper and lower samples, and a register write arriving in the same cycle as a load and a tick. The bench places a load one edge after a snapshot request so that the first comparison fails and the retry succeeds. It also loads a new upper half on every cycle of a read to use up the retry budget. Separately, it issues a high-half write and a counter clear in cycles that also carry a load and a tick. A behavioural model, advanced on every clock, predicts the counter, the read data and each snapshot strobe, value and warning, and is compared with the outputs one nanosecond after each edge.

// File: rtl/tsf_pkg.sv
// Shared constants and types for the time-synchronisation counter.
// Assumes a 2-bit register address space.
package tsf_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_UPPER0 = 2'd1,
        RD_LOWER  = 2'd2,
        RD_UPPER1 = 2'd3
    } rd_state_e;
endpackage

// File: rtl/tsf_counter.sv
// Counter core: holds the time value, the low-half shadow and the
// reset toggle flag. Update priority: high-half commit or counter clear
// (one write port, so never both), then beacon load, then tick.
// Assumes at most one register write per cycle.
module tsf_counter
    import tsf_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  bcn_load,
    input  logic [CNT_W-1:0]      bcn_time,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W/2-1:0]    wr_data,
    output logic [CNT_W-1:0]      cnt,
    output logic                  rst_flag
);
    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] shadow_q;
    logic              flag_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hit_lo, hit_hi, hit_tog, clr_now;

    // Decode the write port.
    always_comb begin
        hit_lo  = wr_en && (wr_addr == ADDR_LO);
        hit_hi  = wr_en && (wr_addr == ADDR_HI);
        hit_tog = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0];
        clr_now = hit_tog && !flag_q;
    end

    // Shadow register holding the pending low half.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_q <= '0;
        else if (hit_lo) shadow_q <= wr_data;
    end

    // Toggle flag flipped by every write of the reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit_tog) flag_q <= !flag_q;
    end

    // Counter update with the fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (hit_hi)   cnt_q <= {wr_data, shadow_q};
        else if (clr_now)  cnt_q <= '0;
        else if (bcn_load) cnt_q <= bcn_time;
        else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt      = cnt_q;
    assign rst_flag = flag_q;

    // R2: plain tick advances by exactly one
    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bcn_load && !wr_en) |=> (cnt == $past(cnt) + CNT_W'(1)));
    // R2: no event, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bcn_load && !wr_en) |=> $stable(cnt));
    // R4: high-half write commits both halves
    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_HI) |=> (cnt == {$past(wr_data), $past(shadow_q)}));
    // R5: each write of the reset bit flips the flag
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[0]) |=> (rst_flag != $past(rst_flag)));
    // R5: a rising toggle clears the counter
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[0] && !rst_flag) |=> (cnt == '0));
    // R6: beacon load wins over tick
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bcn_load && !wr_en) |=> (cnt == $past(bcn_time)));
endmodule

// File: rtl/tsf_regmux.sv
// Read decode: picks one 32-bit view of the counter state by address.
// Purely combinational; assumes CNT_W is even.
module tsf_regmux
    import tsf_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                rst_flag,
    output logic [CNT_W/2-1:0]  rdata
);
    localparam int HALF_W = CNT_W / 2;

    // Select the addressed view.
    always_comb begin
        case (addr)
            ADDR_LO:   rdata = cnt[HALF_W-1:0];
            ADDR_HI:   rdata = cnt[CNT_W-1:HALF_W];
            ADDR_CTRL: rdata = {{(HALF_W-1){1'b0}}, rst_flag};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsf_snap_reader.sv
// Coherent snapshot reader: upper, then (lower, upper) until two upper
// samples match or MAX_TRY comparisons have failed. Reads through its
// own read-decode view of the counter, one half per cycle.
module tsf_snap_reader
    import tsf_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int MAX_TRY = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic [HALF_W-1:0]     rd_data,
    output logic                  busy,
    output logic                  valid,
    output logic [2*HALF_W-1:0]   value,
    output logic                  warn
);
    localparam int TRY_W = $clog2(MAX_TRY + 1);

    rd_state_e          st_q;
    logic [HALF_W-1:0]  up_q, lo_q;
    logic [TRY_W-1:0]   try_q;
    logic               valid_q, warn_q;
    logic [2*HALF_W-1:0] value_q;
    logic               match, last_try;

    // Address the upper half except while sampling the lower half.
    always_comb begin
        rd_addr  = (st_q == RD_LOWER) ? ADDR_LO : ADDR_HI;
        match    = (rd_data == up_q);
        last_try = (try_q == TRY_W'(MAX_TRY - 1));
    end

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RD_IDLE;
            up_q    <= '0;
            lo_q    <= '0;
            try_q   <= '0;
            valid_q <= 1'b0;
            warn_q  <= 1'b0;
            value_q <= '0;
        end else begin
            valid_q <= 1'b0;
            case (st_q)
                RD_IDLE:   if (req) st_q <= RD_UPPER0;
                RD_UPPER0: begin
                    up_q <= rd_data;
                    st_q <= RD_LOWER;
                end
                RD_LOWER:  begin
                    lo_q <= rd_data;
                    st_q <= RD_UPPER1;
                end
                RD_UPPER1: begin
                    if (match || last_try) begin
                        valid_q <= 1'b1;
                        warn_q  <= !match;
                        value_q <= {rd_data, lo_q};
                        try_q   <= '0;
                        st_q    <= RD_IDLE;
                    end else begin
                        up_q  <= rd_data;
                        try_q <= try_q + TRY_W'(1);
                        st_q  <= RD_LOWER;
                    end
                end
                default:   st_q <= RD_IDLE;
            endcase
        end
    end

    assign busy  = (st_q != RD_IDLE);
    assign valid = valid_q;
    assign value = value_q;
    assign warn  = warn_q;

    // R8: an accepted request makes the reader busy
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
    // R9: retry count stays inside the budget
    a_r9_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (try_q < TRY_W'(MAX_TRY)));
    // R10: completion strobe is one cycle wide
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R10: result held between completions
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(value) && $stable(warn)));
endmodule

// File: rtl/tsf_timer_top.sv
// Top: counter core, host read decode, and snapshot reader with its own
// read decode. Assumes tick_us is a one-cycle pulse at most once per cycle.
module tsf_timer_top #(
    parameter int CNT_W   = 64,
    parameter int MAX_TRY = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_us,
    input  logic                  bcn_load,
    input  logic [CNT_W-1:0]      bcn_time,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_addr,
    input  logic [CNT_W/2-1:0]    bus_wdata,
    input  logic [1:0]            bus_raddr,
    output logic [CNT_W/2-1:0]    bus_rdata,
    input  logic                  snap_req,
    output logic                  snap_busy,
    output logic                  snap_valid,
    output logic [CNT_W-1:0]      snap_value,
    output logic                  snap_warn
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  cnt;
    logic              rst_flag;
    logic [1:0]        rdr_addr;
    logic [HALF_W-1:0] rdr_data;

    tsf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .bcn_load(bcn_load),
        .bcn_time(bcn_time), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .cnt(cnt), .rst_flag(rst_flag)
    );

    tsf_regmux #(.CNT_W(CNT_W)) u_host_mux (
        .addr(bus_raddr), .cnt(cnt), .rst_flag(rst_flag), .rdata(bus_rdata)
    );

    tsf_regmux #(.CNT_W(CNT_W)) u_rdr_mux (
        .addr(rdr_addr), .cnt(cnt), .rst_flag(rst_flag), .rdata(rdr_data)
    );

    tsf_snap_reader #(.HALF_W(HALF_W), .MAX_TRY(MAX_TRY)) u_rdr (
        .clk(clk), .rst_n(rst_n), .req(snap_req), .rd_addr(rdr_addr),
        .rd_data(rdr_data), .busy(snap_busy), .valid(snap_valid),
        .value(snap_value), .warn(snap_warn)
    );
endmodule

// File: tb/tsf_timer_top_tb.sv
`timescale 1ns/1ps
module tsf_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0, bcn_load = 1'b0, bus_wr = 1'b0, snap_req = 1'b0;
    logic [63:0] bcn_time = '0;
    logic [1:0]  bus_addr = '0, bus_raddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        snap_busy, snap_valid, snap_warn;
    logic [63:0] snap_value;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tsf_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bcn_load(bcn_load),
        .bcn_time(bcn_time), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .snap_req(snap_req), .snap_busy(snap_busy), .snap_valid(snap_valid),
        .snap_value(snap_value), .snap_warn(snap_warn)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Behavioural reference model, stepped on each edge.
    logic [63:0] m_cnt = '0;
    logic [31:0] m_sh = '0, m_u1 = '0, m_lo = '0;
    logic        m_flag = 0, m_valid = 0, m_warn = 0;
    logic [63:0] m_val = '0;
    int          m_st = 0, m_try = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_sh = '0; m_flag = 0; m_st = 0; m_try = 0;
            m_valid = 0; m_warn = 0; m_val = '0; m_u1 = '0; m_lo = '0;
        end else begin
            logic clr;
            logic [31:0] hi_now;
            hi_now = m_cnt[63:32];
            m_valid = 0;
            if (m_st == 0) begin
                if (snap_req) m_st = 1;
            end else if (m_st == 1) begin
                m_u1 = hi_now; m_st = 2;
            end else if (m_st == 2) begin
                m_lo = m_cnt[31:0]; m_st = 3;
            end else begin
                if (hi_now == m_u1 || m_try == 9) begin
                    m_valid = 1; m_warn = (hi_now != m_u1);
                    m_val = {hi_now, m_lo}; m_try = 0; m_st = 0;
                end else begin
                    m_u1 = hi_now; m_try++; m_st = 2;
                end
            end
            clr = 0;
            if (bus_wr && bus_addr == 2'd2 && bus_wdata[0]) begin
                clr = !m_flag; m_flag = !m_flag;
            end
            if (bus_wr && bus_addr == 2'd1) m_cnt = {bus_wdata, m_sh};
            else if (clr)                   m_cnt = '0;
            else if (bcn_load)              m_cnt = bcn_time;
            else if (tick_us)               m_cnt = m_cnt + 64'd1;
            if (bus_wr && bus_addr == 2'd0) m_sh = bus_wdata;
        end
    end

    // Per-cycle comparison, 1 ns after the edge.
    always @(posedge clk) begin
        logic [31:0] e_rd;
        #1;
        if (rst_n && !done) begin
            case (bus_raddr)
                2'd0: e_rd = m_cnt[31:0];
                2'd1: e_rd = m_cnt[63:32];
                2'd2: e_rd = {31'd0, m_flag};
                default: e_rd = '0;
            endcase
            chk("R7 rdata", {32'd0, bus_rdata}, {32'd0, e_rd});
            chk("R8 busy", {63'd0, snap_busy}, {63'd0, (m_st != 0)});
            chk("R10 valid", {63'd0, snap_valid}, {63'd0, m_valid});
            chk("R9 value", snap_value, m_val);
            chk("R9 warn", {63'd0, snap_warn}, {63'd0, m_warn});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        bus_raddr = a; #1;
        chk(tag, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_us = 1;
        end
        @(negedge clk); tick_us = 0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (snap_valid) seen = 1;
        end
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 lo", 2'd0, 32'h0);
        rd_chk("R1 hi", 2'd1, 32'h0);
        rd_chk("R1 ctrl", 2'd2, 32'h0);
        chk("R1 busy/valid/warn", {61'd0, snap_busy, snap_valid, snap_warn}, 64'd0);
        chk("R1 value", snap_value, 64'd0);

        // R2 carry and wrap
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0);
        rd_chk("R4 lo", 2'd0, 32'hFFFF_FFFF);
        ticks(1);
        rd_chk("R2 carry lo", 2'd0, 32'h0);
        rd_chk("R2 carry hi", 2'd1, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        ticks(1);
        rd_chk("R2 wrap lo", 2'd0, 32'h0);
        rd_chk("R2 wrap hi", 2'd1, 32'h0);

        // R3 low write lands only in the shadow
        wr(2'd0, 32'h1111_1111); wr(2'd1, 32'h2222_2222);
        wr(2'd0, 32'h3333_3333);
        rd_chk("R3 lo held", 2'd0, 32'h1111_1111);
        rd_chk("R3 hi held", 2'd1, 32'h2222_2222);
        ticks(3);
        rd_chk("R3 ticking", 2'd0, 32'h1111_1114);

        // R4 commit beats load and tick
        @(negedge clk);
        bus_wr = 1; bus_addr = 2'd1; bus_wdata = 32'h4444_4444;
        bcn_load = 1; bcn_time = 64'hDEAD_BEEF_0BAD_F00D; tick_us = 1;
        @(negedge clk); bus_wr = 0; bcn_load = 0; tick_us = 0;
        rd_chk("R4 hi", 2'd1, 32'h4444_4444);
        rd_chk("R4 lo", 2'd0, 32'h3333_3333);

        // R5 toggle reset
        @(negedge clk);
        bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'h1;
        bcn_load = 1; bcn_time = 64'h1234_5678_9ABC_DEF0; tick_us = 1;
        @(negedge clk); bus_wr = 0; bcn_load = 0; tick_us = 0;
        rd_chk("R5 flag set", 2'd2, 32'h1);
        rd_chk("R5 clear lo", 2'd0, 32'h0);
        rd_chk("R5 clear hi", 2'd1, 32'h0);
        ticks(2);
        wr(2'd2, 32'h1);
        rd_chk("R5 flag back", 2'd2, 32'h0);
        rd_chk("R5 no clear", 2'd0, 32'h2);
        wr(2'd2, 32'hFFFF_FFFE);
        rd_chk("R5 bit0 clear", 2'd2, 32'h0);
        rd_chk("R5 bit0 clear cnt", 2'd0, 32'h2);
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk("R7 addr3", 2'd3, 32'h0);
        rd_chk("R7 addr3 write", 2'd0, 32'h2);

        // R6 load beats tick
        @(negedge clk);
        bcn_load = 1; bcn_time = 64'h0000_0005_0000_0000; tick_us = 1;
        @(negedge clk); bcn_load = 0; tick_us = 0;
        rd_chk("R6 hi", 2'd1, 32'h5);
        rd_chk("R6 lo", 2'd0, 32'h0);

        // R8 stable snapshot
        @(negedge clk); snap_req = 1;
        @(negedge clk); snap_req = 0;
        chk("R8 busy", {63'd0, snap_busy}, 64'd1);
        wait_valid(seen);
        chk("R8 done", {63'd0, seen}, 64'd1);
        chk("R8 value", snap_value, 64'h0000_0005_0000_0000);
        chk("R8 warn", {63'd0, snap_warn}, 64'd0);
        @(negedge clk);
        chk("R10 one cycle", {63'd0, snap_valid}, 64'd0);
        chk("R10 held", snap_value, 64'h0000_0005_0000_0000);

        // R9 load between upper samples, retry succeeds
        @(negedge clk); snap_req = 1;
        @(negedge clk); snap_req = 0; bcn_load = 1; bcn_time = 64'h0000_0007_0000_0010;
        @(negedge clk); bcn_load = 0;
        wait_valid(seen);
        chk("R9 retry done", {63'd0, seen}, 64'd1);
        chk("R9 retry value", snap_value, 64'h0000_0007_0000_0010);
        chk("R9 retry warn", {63'd0, snap_warn}, 64'd0);

        // R9 upper changes every cycle: budget exhausted
        @(negedge clk); snap_req = 1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); snap_req = 0;
            if (snap_valid && !seen) begin
                seen = 1;
                chk("R9 warn set", {63'd0, snap_warn}, 64'd1);
                chk("R9 last lower", {32'd0, snap_value[31:0]}, 64'd0);
            end
            bcn_load = 1; bcn_time = {32'(i + 100), 32'h0};
        end
        @(negedge clk); bcn_load = 0;
        chk("R9 exhausted", {63'd0, seen}, 64'd1);

        // R10 requests while busy are dropped
        @(negedge clk); snap_req = 1;
        @(negedge clk); snap_req = 1;
        @(negedge clk); snap_req = 1;
        @(negedge clk); snap_req = 0;
        wait_valid(seen);
        chk("R10 first done", {63'd0, seen}, 64'd1);
        repeat (8) @(negedge clk);
        chk("R10 no queued", {63'd0, snap_busy}, 64'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired got=%0d exp=<20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule